// File: doc/BRIEF.md
# Bus Response Expectation Checker

This block watches the response side of a memory-mapped bus master and decides, for every response that is accepted, whether its value belongs to the set of responses that the issuing command allowed. The command carries a 3-bit expectation code. Each code selects a set of allowed response values: plain success only, exclusive success only, either kind of success, error only, or anything at all. The read channel is checked on every accepted data beat. The write channel is checked on its single accepted response.

A mismatch produces a one-cycle error pulse in the cycle after the failing handshake. It also sets a sticky error flag, which stays set until software-side logic raises the clear input. The block also records the value of the offending response and the channel it came from, so that the first look at a failure shows what arrived. Each channel has its own code input, so a traffic generator can apply the code of the command currently in flight on each channel.

Top module: `resp_expect_chk`

## Requirements
- R1: While reset is low and in the first cycle after reset, `err_pulse`, `err_sticky`, `cap_resp` and `cap_is_wr` are all 0.
- R2: Response encodings are OKAY=2'b00, EXOKAY=2'b01, SLVERR=2'b10 and DECERR=2'b11. Codes 3'd0 and 3'd1 accept only OKAY.
- R3: Code 3'd2 accepts only EXOKAY.
- R4: Code 3'd3 accepts OKAY or EXOKAY and rejects both error responses.
- R5: Code 3'd4 accepts only SLVERR or DECERR.
- R6: Codes 3'd5, 3'd6 and 3'd7 accept every response value.
- R7: The read channel is checked on every beat with `rd_valid && rd_ready`. A burst with one bad beat among good ones is flagged, and a beat without the handshake is ignored whatever its response is.
- R8: The write channel is checked only when `wr_valid && wr_ready` are both high.
- R9: `err_pulse` is high in the cycle after a handshake whose response falls outside its allowed set. It is high for exactly one cycle per such cycle, and it is low in every other cycle.
- R10: `err_sticky` becomes 1 with the pulse and holds until a cycle in which `clr_err` is high and no mismatch occurs. If a mismatch and a clear fall in the same cycle, the flag stays set.
- R11: On each mismatch, `cap_resp` takes the offending response and `cap_is_wr` takes the channel it came from (1 = write). If both channels mismatch in the same cycle, the write response is recorded. Without a mismatch, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Clears the sticky error flag |
| rd_valid | input | 1 | Read data beat valid |
| rd_ready | input | 1 | Read data beat accepted |
| rd_resp | input | RESP_W | Response of the read beat |
| rd_code | input | CODE_W | Expectation code for the read command in flight |
| wr_valid | input | 1 | Write response valid |
| wr_ready | input | 1 | Write response accepted |
| wr_resp | input | RESP_W | Write response value |
| wr_code | input | CODE_W | Expectation code for the write command in flight |
| err_pulse | output | 1 | One-cycle mismatch indication |
| err_sticky | output | 1 | Mismatch seen since last clear |
| cap_resp | output | RESP_W | Response value of the latest mismatch |
| cap_is_wr | output | 1 | Latest mismatch came from the write channel |

## Verification
Three situations are hard to reach from the ports. The first is a mismatch on both channels in the same cycle, which must record the write response. The second is a mismatch that coincides with a clear, which must leave the flag set. The third is a bad beat buried inside a read burst whose other beats are good. Random stimulus draws the handshake signals, responses, codes and the clear input independently, with the clear input rare. Directed steps then force each of these three collisions on purpose. Every pair of code and response is also driven on both channels.

// File: rtl/resp_expect_chk.sv
module resp_expect_chk #(
  parameter int RESP_W = 2,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              rd_valid,
  input  logic              rd_ready,
  input  logic [RESP_W-1:0] rd_resp,
  input  logic [CODE_W-1:0] rd_code,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [RESP_W-1:0] wr_resp,
  input  logic [CODE_W-1:0] wr_code,
  output logic              err_pulse,
  output logic              err_sticky,
  output logic [RESP_W-1:0] cap_resp,
  output logic              cap_is_wr
);
  localparam logic [RESP_W-1:0] OKAY   = RESP_W'(0);
  localparam logic [RESP_W-1:0] EXOKAY = RESP_W'(1);

  function automatic logic allowed(input logic [CODE_W-1:0] code,
                                   input logic [RESP_W-1:0] resp);
    case (code)
      CODE_W'(0), CODE_W'(1): allowed = (resp == OKAY);
      CODE_W'(2):             allowed = (resp == EXOKAY);
      CODE_W'(3):             allowed = (resp == OKAY) || (resp == EXOKAY);
      CODE_W'(4):             allowed = resp[RESP_W-1];
      default:                allowed = 1'b1;
    endcase
  endfunction

  logic rd_bad, wr_bad, any_bad;

  assign rd_bad  = rd_valid && rd_ready && !allowed(rd_code, rd_resp);
  assign wr_bad  = wr_valid && wr_ready && !allowed(wr_code, wr_resp);
  assign any_bad = rd_bad || wr_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
      cap_resp   <= '0;
      cap_is_wr  <= 1'b0;
    end else begin
      err_pulse <= any_bad;
      if (any_bad)      err_sticky <= 1'b1;
      else if (clr_err) err_sticky <= 1'b0;
      if (wr_bad) begin
        cap_resp  <= wr_resp;
        cap_is_wr <= 1'b1;
      end else if (rd_bad) begin
        cap_resp  <= rd_resp;
        cap_is_wr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/resp_expect_chk_sva.sv
module resp_expect_chk_sva #(
  parameter int RESP_W = 2,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_err,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [RESP_W-1:0] rd_resp,
  input logic [CODE_W-1:0] rd_code,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [RESP_W-1:0] wr_resp,
  input logic [CODE_W-1:0] wr_code,
  input logic              err_pulse,
  input logic              err_sticky,
  input logic [RESP_W-1:0] cap_resp,
  input logic              cap_is_wr
);
  logic rd_hs, wr_hs;
  assign rd_hs = rd_valid && rd_ready;
  assign wr_hs = wr_valid && wr_ready;

  AST_PULSE_MARKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky); // R10
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clr_err) |=> err_sticky); // R10
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hs && !wr_hs) |=> !err_pulse); // R9
  AST_ANY_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hs && rd_hs && rd_code >= CODE_W'(5)) |=> !err_pulse); // R6
  AST_WR_OKAY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wr_code == CODE_W'(0) && wr_resp != RESP_W'(0)) |=> (err_pulse && cap_is_wr)); // R2
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hs && !wr_hs) |=> ($stable(cap_resp) && $stable(cap_is_wr))); // R11
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wr_code == CODE_W'(2) && wr_resp != RESP_W'(1)) |=> (cap_is_wr && cap_resp == $past(wr_resp))); // R11
endmodule

bind resp_expect_chk resp_expect_chk_sva #(.RESP_W(RESP_W), .CODE_W(CODE_W)) u_sva (.*);

// File: tb/resp_expect_chk_bench.sv
module resp_expect_chk_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_err = 1'b0;
  logic       rd_valid = 1'b0, rd_ready = 1'b0, wr_valid = 1'b0, wr_ready = 1'b0;
  logic [1:0] rd_resp = '0, wr_resp = '0;
  logic [2:0] rd_code = '0, wr_code = '0;
  logic       err_pulse, err_sticky, cap_is_wr;
  logic [1:0] cap_resp;

  int checks = 0, errors = 0, cycles = 0;
  logic       e_pulse = 0, e_sticky = 0, e_wr = 0;
  logic [1:0] e_resp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_expect_chk u_resp_expect_chk (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic bit accepts(input logic [2:0] code, input logic [1:0] r);
    if (code <= 3'd1) return r == 2'b00;
    if (code == 3'd2) return r == 2'b01;
    if (code == 3'd3) return r[1] == 1'b0;
    if (code == 3'd4) return r[1] == 1'b1;
    return 1'b1;
  endfunction

  function automatic string code_tag(input logic [2:0] code);
    if (code <= 3'd1) return "R2";
    if (code == 3'd2) return "R3";
    if (code == 3'd3) return "R4";
    if (code == 3'd4) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic rr, input logic [1:0] rs, input logic [2:0] rc,
                      input logic wv, input logic wrd, input logic [1:0] ws, input logic [2:0] wc,
                      input logic clr, input string ptag);
    logic rb, wb;
    rd_valid = rv; rd_ready = rr; rd_resp = rs; rd_code = rc;
    wr_valid = wv; wr_ready = wrd; wr_resp = ws; wr_code = wc;
    clr_err = clr;
    rb = rv && rr && !accepts(rc, rs);
    wb = wv && wrd && !accepts(wc, ws);
    e_pulse = rb || wb;
    if (rb || wb) e_sticky = 1'b1; else if (clr) e_sticky = 1'b0;
    if (wb) begin e_resp = ws; e_wr = 1'b1; end
    else if (rb) begin e_resp = rs; e_wr = 1'b0; end
    @(negedge clk);
    chk(ptag, {31'd0, err_pulse}, {31'd0, e_pulse});
    chk("R10", {31'd0, err_sticky}, {31'd0, e_sticky});
    chk("R11", {29'd0, cap_is_wr, cap_resp}, {29'd0, e_wr, e_resp});
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1", {28'd0, err_pulse, err_sticky, cap_is_wr, cap_resp[0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'd0, err_pulse, err_sticky, cap_is_wr, cap_resp[0]}, 32'd0);
    chk("R1", {30'd0, cap_resp}, 32'd0);

    // Every code against every response, on both channels.
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++) begin
        step(0,0,0,0, 1,1,2'(r),3'(c), 1, code_tag(3'(c)));
        step(1,1,2'(r),3'(c), 0,0,0,0, 1, code_tag(3'(c)));
      end
    // R7: a read burst with one bad beat among good ones, then a non-handshake beat that must be ignored.
    step(1,1,2'b00,3'd0, 0,0,0,0, 1, "R7");
    step(1,1,2'b00,3'd0, 0,0,0,0, 0, "R7");
    step(1,1,2'b10,3'd0, 0,0,0,0, 0, "R7");
    step(1,1,2'b00,3'd0, 0,0,0,0, 0, "R7");
    step(1,0,2'b11,3'd0, 0,0,0,0, 1, "R7");
    step(0,1,2'b11,3'd0, 0,0,0,0, 0, "R7");
    // R8: a write response without the handshake is ignored.
    step(0,0,0,0, 1,0,2'b11,3'd0, 0, "R8");
    step(0,0,0,0, 0,1,2'b11,3'd2, 0, "R8");
    // R11: both channels mismatch in the same cycle, so the write response is recorded.
    step(1,1,2'b01,3'd0, 1,1,2'b10,3'd3, 0, "R11");
    // R10: a mismatch in the same cycle as a clear leaves the flag set.
    step(1,1,2'b11,3'd2, 0,0,0,0, 1, "R10");
    step(0,0,0,0, 0,0,0,0, 1, "R10");
    step(0,0,0,0, 0,0,0,0, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] rc, wc;
      rc = 3'($urandom_range(0, 7));
      wc = 3'($urandom_range(0, 7));
      step(1'($urandom), 1'($urandom), 2'($urandom), rc,
           1'($urandom), 1'($urandom), 2'($urandom), wc,
           ($urandom_range(0, 15) == 0), "R9");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule